// File: doc/BRIEF.md
# Adaptive Context Model Store with Row Snapshot

This block keeps the adaptive probability models used by a binary arithmetic coder. Each model is 7 bits: a 6-bit probability state and a 1-bit most-probable-symbol (MPS) value. A slice starts with an init sweep. The sweep fills every entry of the context RAM from a computed init byte and the slice QP. The block then serves regular bins. The coder presents a context index, and one cycle later the block returns that model's state and MPS. The coder reports the coded bin value, and the block adapts the model and writes it back.

For wavefront-parallel coding, the block can copy the whole context table into a second RAM, one entry per cycle. The copy is taken when the second CTU of a row has finished. A restore sweep copies that snapshot back at the start of the next CTU row. Upstream logic must not start a row until two CTUs of the row above are complete, and it signals this by timing the two sweep commands. While any sweep runs, `busy` is high and bin traffic is refused. A request that is refused must be held until `busy` falls. The context index is computed outside the block.

Top module: `ctx_store`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `busy` and `mdl_valid` are 0.
- R2: An accepted `init_start` holds `busy` high for exactly NUM_CTX cycles. It then leaves entry i holding the model derived from init byte m = (29*i + 154) mod 256 and from q = min(slice_qp, 51). The derivation is: slope = 5*(m>>4) - 45; offset = 8*(m&15) - 16; p = ((slope*q) >>> 4) + offset (floor shift), clipped to 1..126. If p <= 63 the result is state 63-p with MPS 0; otherwise it is state p-64 with MPS 1. `slice_qp` is sampled in the cycle the init is accepted.
- R3: A `bin_req` taken while idle gives `mdl_valid` in the next cycle. `mdl_state` and `mdl_mps` then carry the stored model of `bin_ctx`.
- R4: `upd_valid` adapts the model most recently presented on `mdl_*`. If `upd_bin` equals the MPS, the state rises by 1, but a state of 62 stays at 62. The MPS is kept.
- R5: If `upd_bin` differs from the MPS, the new state is s - (s>>2) - (s!=0 ? 1 : 0). The MPS flips only when s was 0.
- R6: If `upd_valid` and a `bin_req` for the same context fall in the same cycle, the returned model already includes that update.
- R7: An accepted `snap_start` copies the whole table into the snapshot store. An accepted `restore_start` copies the snapshot back. Later updates to the live table do not disturb the snapshot. Each of these sweeps holds `busy` for NUM_CTX+1 cycles.
- R8: When start commands arrive together while idle, the priority is init over restore over snapshot, and the lower-priority commands are dropped. Start commands that arrive while `busy` is high are ignored.
- R9: While `busy` is high, `bin_req` produces no `mdl_valid` and `upd_valid` does not change the table.
- R10: A `bin_req` in the same cycle as an accepted start command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slice_qp | input | 6 | Slice quantizer, sampled on init |
| init_start | input | 1 | Start init sweep |
| snap_start | input | 1 | Start copy of table to snapshot |
| restore_start | input | 1 | Start copy of snapshot to table |
| busy | output | 1 | A sweep is running |
| bin_req | input | 1 | Read request for one regular bin |
| bin_ctx | input | log2(NUM_CTX) | Context index of the request |
| mdl_valid | output | 1 | Model outputs are valid |
| mdl_state | output | 6 | Probability state |
| mdl_mps | output | 1 | MPS value |
| upd_valid | input | 1 | Coded bin result is present |
| upd_bin | input | 1 | Coded bin value |

## Verification
The bench builds the block with NUM_CTX = 16. With that size every sweep runs in a handful of cycles, so the bench can read back and compare every entry after each init, snapshot and restore. The bench also drives 70 same-symbol bins into one context to reach the cap at state 62. It drives 70 opposite-symbol bins into another context so that the state reaches 0 and the MPS flips. Two init sweeps at QP 30 and QP 60 cover both the unclipped and the clipped QP.

// File: rtl/ctxs_pkg.sv
package ctxs_pkg;

  typedef struct packed {
    logic [5:0] state;
    logic       mps;
  } ctx_model_t;

  typedef enum logic [1:0] {SW_IDLE, SW_INIT, SW_SNAP, SW_REST} sweep_op_e;

  localparam int STATE_MAX = 62;
  localparam int QP_MAX    = 51;

  // computed init byte per context index
  function automatic logic [7:0] rom_byte(int unsigned idx);
    return 8'((idx * 29 + 154) % 256);
  endfunction

  function automatic ctx_model_t init_model(logic [7:0] m, logic [5:0] qp);
    int q, slope, offset, pre;
    ctx_model_t r;
    q      = (int'(qp) > QP_MAX) ? QP_MAX : int'(qp);
    slope  = int'(m[7:4]) * 5 - 45;
    offset = (int'(m[3:0]) << 3) - 16;
    pre    = ((slope * q) >>> 4) + offset;
    if (pre < 1)   pre = 1;
    if (pre > 126) pre = 126;
    if (pre <= 63) begin
      r.state = 6'(63 - pre);
      r.mps   = 1'b0;
    end else begin
      r.state = 6'(pre - 64);
      r.mps   = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/ctx_ram.sv
module ctx_ram #(
  parameter int DEPTH = 256,
  parameter int W     = 7,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ctx_sweep.sv
module ctx_sweep
  import ctxs_pkg::*;
#(
  parameter int NUM_CTX = 256,
  localparam int AW     = $clog2(NUM_CTX),
  localparam int CW     = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_go,
  input  logic          snap_go,
  input  logic          rest_go,
  output sweep_op_e     op,
  output logic          accept,
  output logic [AW-1:0] idx,
  output logic          copy_wr,
  output logic [AW-1:0] copy_idx
);
  sweep_op_e     op_q;
  logic [CW-1:0] cnt_q;

  assign op       = op_q;
  assign accept   = (op_q == SW_IDLE) && (init_go || snap_go || rest_go);
  assign idx      = cnt_q[AW-1:0];
  assign copy_wr  = ((op_q == SW_SNAP) || (op_q == SW_REST)) && (cnt_q != '0);
  assign copy_idx = AW'(cnt_q - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q  <= SW_IDLE;
      cnt_q <= '0;
    end else begin
      case (op_q)
        SW_IDLE: begin
          cnt_q <= '0;
          if (init_go)      op_q <= SW_INIT;
          else if (rest_go) op_q <= SW_REST;
          else if (snap_go) op_q <= SW_SNAP;
        end
        SW_INIT: begin
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == CW'(NUM_CTX - 1)) op_q <= SW_IDLE;
        end
        default: begin
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == CW'(NUM_CTX)) op_q <= SW_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/ctx_adapt.sv
module ctx_adapt
  import ctxs_pkg::*;
(
  input  ctx_model_t cur,
  input  logic       bin,
  output ctx_model_t nxt
);
  always_comb begin
    nxt = cur;
    if (bin == cur.mps) begin
      if (cur.state < 6'(STATE_MAX)) nxt.state = cur.state + 6'd1;
    end else begin
      nxt.state = cur.state - (cur.state >> 2) - 6'(cur.state != 6'd0);
      if (cur.state == 6'd0) nxt.mps = ~cur.mps;
    end
  end
endmodule

// File: rtl/ctx_store.sv
module ctx_store
  import ctxs_pkg::*;
#(
  parameter int NUM_CTX = 256,
  localparam int AW     = $clog2(NUM_CTX),
  localparam int MW     = $bits(ctx_model_t)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [5:0]    slice_qp,
  input  logic          init_start,
  input  logic          snap_start,
  input  logic          restore_start,
  output logic          busy,
  input  logic          bin_req,
  input  logic [AW-1:0] bin_ctx,
  output logic          mdl_valid,
  output logic [5:0]    mdl_state,
  output logic          mdl_mps,
  input  logic          upd_valid,
  input  logic          upd_bin
);
  sweep_op_e     op;
  logic          accept, copy_wr;
  logic [AW-1:0] sw_idx, copy_idx;
  logic [5:0]    qp_q;

  ctx_sweep #(.NUM_CTX(NUM_CTX)) u_sweep (
    .clk(clk), .rst(rst),
    .init_go(init_start), .snap_go(snap_start), .rest_go(restore_start),
    .op(op), .accept(accept), .idx(sw_idx),
    .copy_wr(copy_wr), .copy_idx(copy_idx)
  );

  assign busy = (op != SW_IDLE);

  logic rd_go, upd_go;
  assign rd_go  = bin_req && !busy && !accept;
  assign upd_go = upd_valid && !busy;

  // live table and snapshot store
  logic          live_we;
  logic [AW-1:0] live_waddr, live_raddr;
  logic [MW-1:0] live_wdata, live_rdata, snap_rdata;

  ctx_ram #(.DEPTH(NUM_CTX), .W(MW)) u_live (
    .clk(clk), .we(live_we), .waddr(live_waddr), .wdata(live_wdata),
    .raddr(live_raddr), .rdata(live_rdata)
  );

  ctx_ram #(.DEPTH(NUM_CTX), .W(MW)) u_snap (
    .clk(clk), .we(copy_wr && (op == SW_SNAP)), .waddr(copy_idx),
    .wdata(live_rdata), .raddr(sw_idx), .rdata(snap_rdata)
  );

  // presented model, held model and adaptation
  logic          fwd_hit;
  ctx_model_t    fwd_mdl, out_mdl, hold_mdl, cur_mdl, new_mdl;
  logic [AW-1:0] ctx_d, hold_ctx, cur_ctx;

  assign out_mdl   = fwd_hit ? fwd_mdl : ctx_model_t'(live_rdata);
  assign mdl_state = out_mdl.state;
  assign mdl_mps   = out_mdl.mps;
  assign cur_mdl   = mdl_valid ? out_mdl : hold_mdl;
  assign cur_ctx   = mdl_valid ? ctx_d : hold_ctx;

  ctx_adapt u_adapt (.cur(cur_mdl), .bin(upd_bin), .nxt(new_mdl));

  always_comb begin
    live_we    = 1'b0;
    live_waddr = cur_ctx;
    live_wdata = MW'(new_mdl);
    live_raddr = bin_ctx;
    case (op)
      SW_INIT: begin
        live_we    = 1'b1;
        live_waddr = sw_idx;
        live_wdata = MW'(init_model(rom_byte(int'(sw_idx)), qp_q));
      end
      SW_REST: begin
        live_we    = copy_wr;
        live_waddr = copy_idx;
        live_wdata = snap_rdata;
      end
      SW_SNAP: live_raddr = sw_idx;
      default: live_we = upd_go;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mdl_valid <= 1'b0;
      fwd_hit   <= 1'b0;
      fwd_mdl   <= '0;
      ctx_d     <= '0;
      hold_mdl  <= '0;
      hold_ctx  <= '0;
      qp_q      <= '0;
    end else begin
      mdl_valid <= rd_go;
      ctx_d     <= bin_ctx;
      fwd_hit   <= upd_go && (cur_ctx == bin_ctx);
      fwd_mdl   <= new_mdl;
      if (mdl_valid) begin
        hold_mdl <= out_mdl;
        hold_ctx <= ctx_d;
      end
      if (accept && init_start) qp_q <= slice_qp;
    end
  end
endmodule

// File: rtl/ctx_store_chk.sv
module ctx_store_chk #(
  parameter int NUM_CTX = 256,
  localparam int AW     = $clog2(NUM_CTX)
) (
  input logic          clk,
  input logic          rst,
  input logic [5:0]    slice_qp,
  input logic          init_start,
  input logic          snap_start,
  input logic          restore_start,
  input logic          busy,
  input logic          bin_req,
  input logic [AW-1:0] bin_ctx,
  input logic          mdl_valid,
  input logic [5:0]    mdl_state,
  input logic          mdl_mps,
  input logic          upd_valid,
  input logic          upd_bin
);
  int   run_len;
  logic busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len <= 0;
      busy_q  <= 1'b0;
    end else begin
      busy_q <= busy;
      if (busy) run_len <= busy_q ? run_len + 1 : 1;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!busy && !mdl_valid));

  a_r3_read_answers: assert property (@(posedge clk) disable iff (rst)
    (bin_req && !busy && !init_start && !snap_start && !restore_start) |=> mdl_valid);

  a_r9_busy_mute: assert property (@(posedge clk) disable iff (rst)
    busy |=> !mdl_valid);

  a_r8_start_taken: assert property (@(posedge clk) disable iff (rst)
    (!busy && (init_start || snap_start || restore_start)) |=> busy);

  a_r4_state_cap: assert property (@(posedge clk) disable iff (rst)
    mdl_valid |-> (mdl_state <= 6'd62));

  a_r7_sweep_len: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == NUM_CTX || run_len == NUM_CTX + 1));
endmodule

bind ctx_store ctx_store_chk #(.NUM_CTX(NUM_CTX)) u_chk (.*);

// File: tb/test_ctx_store.sv
module test_ctx_store;
  localparam int N  = 16;
  localparam int AW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [5:0]    slice_qp = '0;
  logic          init_start = 0, snap_start = 0, restore_start = 0;
  logic          busy;
  logic          bin_req = 0;
  logic [AW-1:0] bin_ctx = '0;
  logic          mdl_valid, mdl_mps;
  logic [5:0]    mdl_state;
  logic          upd_valid = 0, upd_bin = 0;

  always #10 clk = ~clk;

  ctx_store #(.NUM_CTX(N)) i_ctx_store (.*);

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct {int st; int mps; string tag;} exp_t;
  exp_t q[$];
  exp_t e;
  int m_st[N], m_mps[N], s_st[N], s_mps[N];

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic void model_init(int qp);
    for (int i = 0; i < N; i++) begin
      int m, qq, slope, off, p;
      m = (i * 29 + 154) % 256;
      qq = (qp > 51) ? 51 : qp;
      slope = (m / 16) * 5 - 45;
      off = (m % 16) * 8 - 16;
      p = ((slope * qq) >>> 4) + off;
      if (p < 1) p = 1;
      if (p > 126) p = 126;
      if (p <= 63) begin m_st[i] = 63 - p; m_mps[i] = 0; end
      else begin m_st[i] = p - 64; m_mps[i] = 1; end
    end
  endfunction

  function automatic void model_step(int c, int b);
    if (b == m_mps[c]) begin
      if (m_st[c] < 62) m_st[c]++;
    end else begin
      if (m_st[c] == 0) m_mps[c] = 1 - m_mps[c];
      m_st[c] = m_st[c] - m_st[c] / 4 - ((m_st[c] != 0) ? 1 : 0);
    end
  endfunction

  // monitor: compares every presented model with the scoreboard
  always @(negedge clk) begin
    if (!rst && mdl_valid) begin
      if (q.size() == 0) chk(1'b0, "R9 unexpected model", 1, 0);
      else begin
        e = q.pop_front();
        chk(int'(mdl_state) == e.st, {e.tag, " state"}, int'(mdl_state), e.st);
        chk(int'(mdl_mps) == e.mps, {e.tag, " mps"}, int'(mdl_mps), e.mps);
      end
    end
  end

  task automatic push(int c, string tag);
    exp_t x;
    x.st = m_st[c]; x.mps = m_mps[c]; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic rd(int c, string tag);
    @(negedge clk); bin_req = 1; bin_ctx = AW'(c); push(c, tag);
    @(negedge clk); bin_req = 0;
  endtask

  task automatic read_all(string tag);
    for (int i = 0; i < N; i++) rd(i, tag);
  endtask

  task automatic code(int c, int b, string tag);
    @(negedge clk); bin_req = 1; bin_ctx = AW'(c); push(c, tag);
    @(negedge clk); bin_req = 0; upd_valid = 1; upd_bin = b[0]; model_step(c, b);
    @(negedge clk); upd_valid = 0;
  endtask

  // update and same-context request in one cycle
  task automatic fwd(int c, int b);
    @(negedge clk); bin_req = 1; bin_ctx = AW'(c); push(c, "R6 first");
    @(negedge clk); upd_valid = 1; upd_bin = b[0]; model_step(c, b); push(c, "R6 forwarded");
    @(negedge clk); upd_valid = 0; bin_req = 0;
  endtask

  task automatic sweep(bit i, bit s, bit r, int exp_len, string tag);
    int len;
    @(negedge clk); init_start = i; snap_start = s; restore_start = r;
    @(negedge clk); init_start = 0; snap_start = 0; restore_start = 0;
    len = 0;
    while (busy) begin len++; @(negedge clk); end
    chk(len == exp_len, tag, len, exp_len);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int len;
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1 busy in reset", int'(busy), 0);
    chk(mdl_valid == 0, "R1 valid in reset", int'(mdl_valid), 0);
    rst = 0;
    @(negedge clk);
    chk(busy == 0 && mdl_valid == 0, "R1 after reset", int'(busy), 0);

    // R2: init at QP 30
    slice_qp = 6'd30;
    sweep(1, 0, 0, N, "R2 init length");
    model_init(30);
    read_all("R2 init qp30");

    // R4, R5: mixed patterns
    for (int k = 0; k < 40; k++) begin
      int c = (k * 5) % N;
      code(c, ((k % 3) == 0) ? 1 - m_mps[c] : m_mps[c], "R4 R5 mixed");
    end
    read_all("R4 R5 table");
    for (int k = 0; k < 70; k++) code(5, m_mps[5], "R4 climb");
    rd(5, "R4 cap at 62");
    for (int k = 0; k < 70; k++) code(6, 1 - m_mps[6], "R5 fall and flip");
    rd(6, "R5 after flips");

    // R6: forwarding
    fwd(7, m_mps[7]);
    fwd(7, 1 - m_mps[7]);
    fwd(8, 1 - m_mps[8]);
    rd(7, "R6 stored");

    // R7: snapshot, modify, restore
    sweep(0, 1, 0, N + 1, "R7 snapshot length");
    s_st = m_st; s_mps = m_mps;
    for (int c = 0; c < 4; c++) code(c, 1 - m_mps[c], "R7 modify");
    read_all("R7 live after modify");
    sweep(0, 0, 1, N + 1, "R7 restore length");
    m_st = s_st; m_mps = s_mps;
    read_all("R7 restored");

    // R8: restore beats snapshot
    code(1, 1 - m_mps[1], "R8 modify");
    code(2, m_mps[2], "R8 modify");
    sweep(0, 1, 1, N + 1, "R8 restore wins length");
    m_st = s_st; m_mps = s_mps;
    read_all("R8 restore wins");

    // R8: init beats snapshot, QP clip
    slice_qp = 6'd60;
    sweep(1, 1, 0, N, "R8 init wins length");
    model_init(60);
    read_all("R2 R8 qp clipped");

    // R9, R8: traffic and starts during busy
    @(negedge clk); slice_qp = 6'd20; init_start = 1;
    @(negedge clk); init_start = 0; slice_qp = 6'd45;
    bin_req = 1; bin_ctx = 3; upd_valid = 1; upd_bin = 1;
    len = 0;
    while (busy) begin
      len++;
      if (len == 4) snap_start = 1;
      if (len == 5) snap_start = 0;
      chk(mdl_valid == 0, "R9 no model while busy", int'(mdl_valid), 0);
      @(negedge clk);
      if (!busy) begin bin_req = 0; upd_valid = 0; end
    end
    bin_req = 0; upd_valid = 0;
    chk(len == N, "R8 init length unchanged", len, N);
    @(negedge clk);
    chk(busy == 0, "R8 start during busy ignored", int'(busy), 0);
    model_init(20);
    read_all("R9 table untouched");

    // R10: request with accepted start
    @(negedge clk); snap_start = 1; bin_req = 1; bin_ctx = 4;
    @(negedge clk); snap_start = 0; bin_req = 0;
    chk(mdl_valid == 0, "R10 request dropped", int'(mdl_valid), 0);
    while (busy) @(negedge clk);
    code(4, 1 - m_mps[4], "R10 later request served");

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R3 all requests answered", q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule